// File: doc/BRIEF.md
# Address Range Access Protection Unit

This unit watches every access the processor puts on its bus and decides whether that read or write is allowed. Software programs up to six address windows. Each window has an aligned base address and a size code that gives a power-of-two size. A privilege register holds a read grant and a write grant for each window. It also holds fallback grants for addresses that fall in no window, one bit that turns checking on, and one bit that forces checking for test purposes.

When an access is not permitted, the unit raises a sticky read-violation or write-violation interrupt one clock later. It also records the address of the offending access. That address stays frozen while any violation is still pending, so software always sees the first one. Software clears each interrupt by writing ones to a clear register. The unit only observes the bus: stopping the bus cycle and any exception handling are done elsewhere.

Top module: `addr_guard`

## Requirements
- R1: After reset both interrupt outputs are low and every register select reads zero.
- R2: Selects 0 to 5 are the window registers. Bits 31:9 hold the base, bits 4:0 hold a size code from 9 to 21, and the window covers 2^code bytes starting at the base rounded down to that size. Bits 8:5 read back as zero.
- R3: A window whose size code is 0 to 8 or above 21 contains no address.
- R4: Select 6 is the privilege register. Bit k grants writes in window k. Bit 10+k grants reads in window k. Bit 9 is the fallback write grant, bit 19 the fallback read grant, bit 31 the enable and bit 30 the test mode.
- R5: An access inside one or more windows is allowed when any of those windows grants its direction. It is a violation otherwise, whatever the fallback bits say.
- R6: An access inside no window is allowed only when the fallback grant for its direction is set.
- R7: Violations are flagged only while the enable bit or the test bit is set. The test bit alone is enough.
- R8: A read violation sets irqRdViol and a write violation sets irqWrViol on the clock edge that samples the access. Each flag stays high until a write to select 8 with bit 0 (read flag) or bit 1 (write flag) set. Reading select 8 returns the read flag in bit 0 and the write flag in bit 1.
- R9: Select 7 returns the captured violation address. A violation loads it only when no flag will remain pending after that cycle's clears. Writes to select 7 have no effect.
- R10: When a clear and a new violation of the same direction fall in the same cycle, the flag stays set. The address is recaptured only if no other flag stays pending.
- R11: Writes to selects 9 to 15 change nothing, and those selects read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regSel | input | 4 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regSel, combinational |
| busValid | input | 1 | An access is on the bus this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 32 | Access address |
| irqRdViol | output | 1 | Sticky read-violation interrupt |
| irqWrViol | output | 1 | Sticky write-violation interrupt |

## Verification
Software clearing a flag and the bus producing a fresh violation can land in the same clock. In that case the new violation must win, and the address must be recaptured only when nothing else stays pending. The bench provokes this by driving a clear write and a violating access in the same cycle, once with only the cleared flag pending and once with a clear of the other direction. A behavioural model follows the rule on every clock, and the flag and the address register are read back right after the edge.

// File: rtl/addr_guard_pkg.sv
`timescale 1ns/1ps
package addr_guard_pkg;
  // layout constants that software decodes
  localparam int CODE_W      = 5;
  localparam int CODE_MIN    = 9;
  localparam int CODE_MAX    = 21;
  localparam int BASE_LSB    = 9;
  localparam int PRIV_WR_LSB = 0;
  localparam int PRIV_GWR    = 9;
  localparam int PRIV_RD_LSB = 10;
  localparam int PRIV_GRD    = 19;
  localparam int PRIV_TEST   = 30;
  localparam int PRIV_EN     = 31;
  localparam int IRQ_RD_BIT  = 0;
  localparam int IRQ_WR_BIT  = 1;

  typedef struct packed {
    logic rdViol;
    logic wrViol;
  } violation_t;

  typedef struct packed {
    logic captureAddr;
    logic rdFlag;
    logic wrFlag;
  } ctlStrobe_t;
endpackage

// File: rtl/addr_guard_dp.sv
`timescale 1ns/1ps
module addr_guard_dp
  import addr_guard_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] regWdata,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  ctlStrobe_t        strb,
  output violation_t        viol,
  output logic [ADDR_W-1:0] regRdata
);
  localparam int SEL_PRIV  = NUM_WIN;
  localparam int SEL_VADDR = NUM_WIN + 1;
  localparam int SEL_IRQ   = NUM_WIN + 2;
  localparam logic [ADDR_W-1:0] RANGE_KEEP =
    {{(ADDR_W-BASE_LSB){1'b1}}, {(BASE_LSB-CODE_W){1'b0}}, {CODE_W{1'b1}}};

  logic [ADDR_W-1:0] rangeQ [NUM_WIN];
  logic [ADDR_W-1:0] privQ;
  logic [ADDR_W-1:0] vaddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WIN; i++) rangeQ[i] <= '0;
      privQ  <= '0;
    end else if (regWe) begin
      for (int i = 0; i < NUM_WIN; i++)
        if (regSel == SEL_W'(i)) rangeQ[i] <= regWdata & RANGE_KEEP;
      if (regSel == SEL_W'(SEL_PRIV)) privQ <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 vaddrQ <= '0;
    else if (strb.captureAddr) vaddrQ <= busAddr;
  end

  // window decode, one comparator per window
  logic [NUM_WIN-1:0] inWin, grantRd, grantWr;
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [CODE_W-1:0] code;
    logic              codeOk;
    logic [ADDR_W-1:0] sizeMask;
    assign code     = rangeQ[g][CODE_W-1:0];
    assign codeOk   = (code >= CODE_W'(CODE_MIN)) && (code <= CODE_W'(CODE_MAX));
    assign sizeMask = ~((ADDR_W'(1) << code) - ADDR_W'(1));
    assign inWin[g]   = codeOk && (((busAddr ^ rangeQ[g]) & sizeMask) == '0);
    assign grantRd[g] = inWin[g] && privQ[PRIV_RD_LSB + g];
    assign grantWr[g] = inWin[g] && privQ[PRIV_WR_LSB + g];
  end

  logic anyIn, rdOk, wrOk, active;
  assign anyIn  = |inWin;
  assign rdOk   = anyIn ? (|grantRd) : privQ[PRIV_GRD];
  assign wrOk   = anyIn ? (|grantWr) : privQ[PRIV_GWR];
  assign active = privQ[PRIV_EN] | privQ[PRIV_TEST];
  assign viol.rdViol = busValid && !busWrite && active && !rdOk;
  assign viol.wrViol = busValid &&  busWrite && active && !wrOk;

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (regSel == SEL_W'(i)) regRdata = rangeQ[i];
    if (regSel == SEL_W'(SEL_PRIV))  regRdata = privQ;
    if (regSel == SEL_W'(SEL_VADDR)) regRdata = vaddrQ;
    if (regSel == SEL_W'(SEL_IRQ)) begin
      regRdata[IRQ_RD_BIT] = strb.rdFlag;
      regRdata[IRQ_WR_BIT] = strb.wrFlag;
    end
  end

  // R5: a granting window always wins
  p_inside_granted_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && (|grantRd)) |-> !viol.rdViol)
    else $error("granted read flagged");
  // R6: fallback write grant covers addresses outside every window
  p_outside_global_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && !anyIn && privQ[PRIV_GWR]) |-> !viol.wrViol)
    else $error("fallback write flagged");
  // R7: nothing is flagged while checking is off
  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!privQ[PRIV_EN] && !privQ[PRIV_TEST]) |-> (!viol.rdViol && !viol.wrViol))
    else $error("violation while disabled");
endmodule

// File: rtl/addr_guard_ctl.sv
`timescale 1ns/1ps
module addr_guard_ctl
  import addr_guard_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int SEL_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [SEL_W-1:0] regSel,
  input  logic [1:0]       clrReq,
  input  violation_t       viol,
  output ctlStrobe_t       strb,
  output logic             irqRdViol,
  output logic             irqWrViol
);
  localparam int SEL_IRQ = NUM_WIN + 2;

  logic rdQ, wrQ, clrSel, clrRd, clrWr, keepRd, keepWr;
  assign clrSel = regWe && (regSel == SEL_W'(SEL_IRQ));
  assign clrRd  = clrSel && clrReq[IRQ_RD_BIT];
  assign clrWr  = clrSel && clrReq[IRQ_WR_BIT];
  assign keepRd = rdQ && !clrRd;
  assign keepWr = wrQ && !clrWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= 1'b0;
      wrQ <= 1'b0;
    end else begin
      rdQ <= keepRd || viol.rdViol;
      wrQ <= keepWr || viol.wrViol;
    end
  end

  assign strb.captureAddr = (viol.rdViol || viol.wrViol) && !(keepRd || keepWr);
  assign strb.rdFlag      = rdQ;
  assign strb.wrFlag      = wrQ;
  assign irqRdViol        = rdQ;
  assign irqWrViol        = wrQ;

  // R8: flag holds without a clear
  p_rd_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqRdViol && !(regWe && regSel == SEL_W'(SEL_IRQ) && clrReq[IRQ_RD_BIT])) |=> irqRdViol)
    else $error("read flag dropped");
  // R8: a flag only rises after a violation
  p_wr_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqWrViol) |-> $past(viol.wrViol))
    else $error("write flag without cause");
  // R10: a new violation beats a same-cycle clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    viol.rdViol |=> irqRdViol)
    else $error("read violation lost");
endmodule

// File: rtl/addr_guard.sv
`timescale 1ns/1ps
module addr_guard
  import addr_guard_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int ADDR_W  = 32,
  parameter int SEL_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              irqRdViol,
  output logic              irqWrViol
);
  violation_t viol;
  ctlStrobe_t strb;

  addr_guard_dp #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .strb(strb), .viol(viol), .regRdata(regRdata)
  );

  addr_guard_ctl #(.NUM_WIN(NUM_WIN), .SEL_W(SEL_W)) ctl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .clrReq(regWdata[1:0]),
    .viol(viol), .strb(strb), .irqRdViol(irqRdViol), .irqWrViol(irqWrViol)
  );
endmodule

// File: tb/addr_guard_tb_top.sv
`timescale 1ns/1ps
module addr_guard_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, regWe, busValid, busWrite, irqRd, irqWr;
  logic [3:0]  regSel;
  logic [31:0] regWdata, regRdata, busAddr;

  addr_guard dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .irqRdViol(irqRd), .irqWrViol(irqWr)
  );

  int    total = 0, bad = 0;
  string curReq = "R1";
  bit    armed = 0;

  // behavioural reference model
  logic [31:0] mRange [6];
  logic [31:0] mPriv = 0, mAddr = 0;
  bit mRd = 0, mWr = 0;
  initial for (int k = 0; k < 6; k++) mRange[k] = 0;

  function automatic bit mAllowed(bit wr, logic [31:0] a);
    bit inAny = 0, ok = 0;
    for (int k = 0; k < 6; k++) begin
      int c = int'(mRange[k][4:0]);
      if (c >= 9 && c <= 21 && ((a >> c) == (mRange[k] >> c))) begin
        inAny = 1;
        if (mPriv[(wr ? 0 : 10) + k]) ok = 1;
      end
    end
    if (!inAny) ok = mPriv[wr ? 9 : 19];
    return ok;
  endfunction

  function automatic logic [31:0] mRead(logic [3:0] s);
    if (s < 6) return mRange[s];
    if (s == 6) return mPriv;
    if (s == 7) return mAddr;
    if (s == 8) return {30'b0, mWr, mRd};
    return 32'b0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < 6; k++) mRange[k] = 0;
      mPriv = 0; mAddr = 0; mRd = 0; mWr = 0;
    end else begin
      bit on, nRd, nWr, cRd, cWr, pend;
      on   = mPriv[31] || mPriv[30];
      nRd  = busValid && !busWrite && on && !mAllowed(0, busAddr);
      nWr  = busValid &&  busWrite && on && !mAllowed(1, busAddr);
      cRd  = regWe && regSel == 8 && regWdata[0];
      cWr  = regWe && regSel == 8 && regWdata[1];
      pend = (mRd && !cRd) || (mWr && !cWr);
      if ((nRd || nWr) && !pend) mAddr = busAddr;
      mRd = (mRd && !cRd) || nRd;
      mWr = (mWr && !cWr) || nWr;
      if (regWe && regSel < 6) mRange[regSel] = regWdata & 32'hFFFF_FE1F;
      if (regWe && regSel == 6) mPriv = regWdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    chk({curReq, " irqRd model"}, {31'b0, irqRd}, {31'b0, mRd});
    chk({curReq, " irqWr model"}, {31'b0, irqWr}, {31'b0, mWr});
    chk({curReq, " rdata model"}, regRdata, mRead(regSel));
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wreg(logic [3:0] s, logic [31:0] d);
    regWe = 1; regSel = s; regWdata = d; tick(); regWe = 0; regWdata = 0;
  endtask
  task automatic acc(bit w, logic [31:0] a);
    busValid = 1; busWrite = w; busAddr = a; tick(); busValid = 0;
  endtask
  task automatic look(logic [3:0] s, logic [31:0] exp, string tag);
    regSel = s; #1; chk(tag, regRdata, exp);
  endtask

  initial begin
    rstN = 0; regWe = 0; regSel = 0; regWdata = 0;
    busValid = 0; busWrite = 0; busAddr = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1; armed = 1;

    curReq = "R1";
    chk("R1 irqRd", {31'b0, irqRd}, 0);
    chk("R1 irqWr", {31'b0, irqWr}, 0);
    for (int s = 0; s < 9; s++) look(4'(s), 0, "R1");
    curReq = "R11";
    for (int s = 9; s < 16; s++) look(4'(s), 0, "R11");

    curReq = "R2";
    wreg(0, 32'h1000_01EC); wreg(1, 32'h2000_0209); wreg(2, 32'h3000_0005);
    wreg(3, 32'h4000_0016); wreg(4, 32'h5004_0015); wreg(5, 32'h2000_000C);
    look(0, 32'h1000_000C, "R2");
    look(4, 32'h5004_0015, "R2");

    curReq = "R4";
    wreg(6, 32'h0000_3C3D);
    look(6, 32'h0000_3C3D, "R4");

    curReq = "R7";
    acc(0, 32'h7000_0000); acc(1, 32'h7000_0000);
    chk("R7 off rd", {31'b0, irqRd}, 0);
    chk("R7 off wr", {31'b0, irqWr}, 0);

    curReq = "R5";
    wreg(6, 32'h8000_3C3D);
    acc(0, 32'h1000_0800); acc(1, 32'h1000_0FFF);
    acc(1, 32'h2000_0300); acc(0, 32'h2000_0300);
    chk("R5 overlap ok", {30'b0, irqWr, irqRd}, 0);

    curReq = "R6";
    acc(0, 32'h1000_1000);
    chk("R6 outside rd", {31'b0, irqRd}, 1);
    look(7, 32'h1000_1000, "R9 first capture");

    curReq = "R9";
    acc(1, 32'h7000_0000);
    chk("R9 wr flag", {31'b0, irqWr}, 1);
    look(7, 32'h1000_1000, "R9 held");
    look(8, 32'h3, "R8 both");
    wreg(7, 32'hFFFF_FFFF);
    look(7, 32'h1000_1000, "R9 ro");

    curReq = "R8";
    wreg(8, 32'h1);
    look(8, 32'h2, "R8 clear rd");
    acc(0, 32'h2000_0400);
    look(8, 32'h3, "R8 rd again");
    look(7, 32'h1000_1000, "R9 held by wr");
    wreg(8, 32'h3);
    look(8, 32'h0, "R8 cleared");

    curReq = "R3";
    acc(0, 32'h3000_0000);
    chk("R3 code5", {31'b0, irqRd}, 1);
    look(7, 32'h3000_0000, "R3 addr");
    acc(1, 32'h4000_0010);
    chk("R3 code22", {31'b0, irqWr}, 1);
    wreg(8, 32'h3);

    curReq = "R2";
    acc(1, 32'h501F_FFFC); acc(1, 32'h5000_0000);
    chk("R2 aligned ok", {31'b0, irqWr}, 0);
    acc(1, 32'h5020_0000);
    chk("R2 past end", {31'b0, irqWr}, 1);
    look(7, 32'h5020_0000, "R2 addr");
    wreg(8, 32'h3);

    curReq = "R6";
    wreg(6, 32'h8008_3E3D);
    acc(0, 32'h7000_0000); acc(1, 32'h7000_0000);
    chk("R6 fallback", {30'b0, irqWr, irqRd}, 0);
    curReq = "R5";
    acc(0, 32'h2000_0A00);
    chk("R5 no fallback inside", {31'b0, irqRd}, 1);
    look(7, 32'h2000_0A00, "R5 addr");

    curReq = "R10";
    regWe = 1; regSel = 8; regWdata = 32'h1;
    busValid = 1; busWrite = 0; busAddr = 32'h2000_0800;
    tick(); regWe = 0; busValid = 0;
    chk("R10 set wins", {31'b0, irqRd}, 1);
    look(7, 32'h2000_0800, "R10 recapture");
    regWe = 1; regSel = 8; regWdata = 32'h2;
    busValid = 1; busWrite = 0; busAddr = 32'h2000_0900;
    tick(); regWe = 0; busValid = 0;
    look(7, 32'h2000_0800, "R10 still held");
    wreg(8, 32'h3);

    curReq = "R7";
    wreg(6, 32'h4000_0000);
    acc(0, 32'h1000_0000);
    chk("R7 test mode", {31'b0, irqRd}, 1);
    wreg(8, 32'h3);

    curReq = "R11";
    for (int s = 9; s < 16; s++) wreg(4'(s), 32'hFFFF_FFFF);
    look(6, 32'h4000_0000, "R11 priv kept");
    look(8, 32'h0, "R11 flags kept");
    look(0, 32'h1000_000C, "R11 range kept");
    for (int s = 9; s < 16; s++) look(4'(s), 0, "R11");

    tick(); tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule